// File: doc/BRIEF.md
# Hashed Page-Table Walker with Atomic Fetch Guard

After a TLB miss, this block fetches one translation entry from a hashed page table in memory. The table is aligned to its own size. The walker then either hands the entry to the TLB or ends the walk with a fault code. An entry comes in one of two sizes: a short entry is one 8-byte beat, and a long entry is four consecutive 8-byte beats. To find the entry, the walker keeps the upper bits of the table base and replaces the bits below the table size with the shifted hash index. No carry passes into the upper bits. Every memory read is issued at the most privileged level. A configuration bit selects whether each beat is taken as big-endian or little-endian.

The walker must behave as one atomic read-and-insert, so it guards the fetch against two kinds of interference:
- A snooped store that lands on a long entry after part of that entry has been read makes the walk end in a TLB miss fault.
- A store that arrives once all beats are in leaves the fetched entry in place, and that entry is installed.
- A purge whose address range covers the virtual address being walked is held off through a ready signal until the walker is idle again.

Faults on a speculative walk are held until an in-order commit confirms them, or dropped on cancel. Every walk that finishes raises a single-cycle done pulse together with either the insert or the fault.

Top module: `hptw_walker`

## Requirements
- R1: The entry address is (base AND NOT m) OR ((index << s) AND m), where m = 2^size_log2 - 1 and s is 3 for short entries and 5 for long entries. Beat k is read at the entry address + 8k. A read request holds its address stable until it is accepted.
- R2: A short walk issues exactly 1 read, and ins_entry then holds that beat in bits [63:0] with zeros above. A long walk issues exactly 4 reads, and ins_entry then holds beat k in bits [64k+63:64k].
- R3: When cfg_big_endian=1, the byte order of every fetched beat is reversed before it is stored. When it is 0, the beat is stored unchanged.
- R4: Every read request carries mem_rd_priv = 0.
- R5: A request marked uncached makes no memory read. It ends in a miss fault: code 1 (instruction TLB miss) when req_is_data=0, or code 2 (data TLB miss) when req_is_data=1.
- R6: Beat 0 is reserved, and the walk ends in a miss fault, if any of its bits [63:56] is set or if its bits [4:2] equal 2 or 3. On a long walk, beat 1 is also reserved if bit 0 or bit 1 is set. Set bits in beats 2 and 3 are not checked and are installed as read.
- R7: When req_xlat_fault=1, meaning the table's own translation faulted, the walk ends in a miss fault and makes no memory read.
- R8: When req_xlat_miss=1, meaning the table's own translation missed in the TLB, the walk ends with code 3 if cfg_ic=1. If cfg_ic=0 it ends with the request's miss code. No memory read is made in either case.
- R9: A snooped store that falls in the 32-byte block of a long entry, after beat 0 has been captured and up to the capture of the last beat, makes the walk end in a miss fault. A store after the last beat, or any store during a short walk, leaves the fetched entry to be installed.
- R10: While a walk is active, pur_ready is 0 for a purge range [pur_lo, pur_hi] that contains the walk's virtual address. pur_ready is 1 for a range that does not contain it, and 1 whenever the walker is idle.
- R11: A fault on a speculative walk (req_spec=1) produces no done until commit is pulsed. A cancel pulse discards it with no done, and the walker returns to idle.
- R12: done is a one-cycle pulse with exactly one of ins_valid or flt_valid. flt_code is nonzero with every fault. req_ready is 1 only while the walker is idle.
- R13: After reset the walker is idle: req_ready=1, pur_ready=1, and mem_rd_valid, done, ins_valid and flt_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | AW | Virtual address that missed |
| req_index | input | AW | Hashed index |
| req_base | input | AW | Table base, aligned to table size |
| req_size_log2 | input | SZW | log2 of table size in bytes |
| req_long | input | 1 | 1 = long entry, 0 = short entry |
| req_is_data | input | 1 | 1 = data miss, 0 = instruction miss |
| req_spec | input | 1 | Walk is speculative |
| req_uncached | input | 1 | Table lies in non-cacheable space |
| req_xlat_fault | input | 1 | Table translation would fault |
| req_xlat_miss | input | 1 | Table translation missed in the TLB |
| cfg_big_endian | input | 1 | Big-endian entry format |
| cfg_ic | input | 1 | Interruption collection enabled |
| commit | input | 1 | In-order confirmation of a held fault |
| cancel | input | 1 | Discard a held fault |
| mem_rd_valid | output | 1 | Beat read request |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | AW | Beat address |
| mem_rd_priv | output | 2 | Privilege level of the read |
| mem_data_valid | input | 1 | Read data present |
| mem_data | input | BEAT_W | Read data beat |
| snp_valid | input | 1 | Snooped store present |
| snp_addr | input | AW | Snooped store address |
| pur_valid | input | 1 | Purge request present |
| pur_ready | output | 1 | Purge may proceed |
| pur_lo | input | AW | Purge range low bound |
| pur_hi | input | AW | Purge range high bound |
| ins_valid | output | 1 | TLB insert |
| ins_long | output | 1 | Inserted entry is long |
| ins_vaddr | output | AW | Virtual address of the insert |
| ins_entry | output | ENT_W | Entry beats, beat 0 lowest |
| flt_valid | output | 1 | Fault reported |
| flt_code | output | 3 | 0 none, 1 instr miss, 2 data miss, 3 table translation |
| done | output | 1 | Walk finished |

## Verification
The checks rely on these assumptions about the inputs:
- The table base is aligned to the table size.
- The memory returns one data beat for each accepted request, and only while the walker waits for it.
- commit and cancel are pulsed only while a speculative fault is held.

The stimulus follows these assumptions. It gives each request an aligned base. Its memory model answers exactly one cycle after it accepts a request. It pulses commit or cancel only after a speculative walk that must fault. Snoops are timed against the beat count: one lands in the middle of a long fetch, one lands just after the last beat, and one lands on the only beat of a short fetch.

// File: rtl/hptw_pkg.sv
package hptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_CHECK,
    ST_FAULT,
    ST_HOLD
  } walk_st_t;

  localparam logic [2:0] FC_NONE = 3'd0;
  localparam logic [2:0] FC_IMISS = 3'd1;
  localparam logic [2:0] FC_DMISS = 3'd2;
  localparam logic [2:0] FC_XLAT = 3'd3;

  localparam logic [1:0] WALK_PRIV = 2'd0;

endpackage

// File: rtl/hptw_addr.sv
module hptw_addr #(
  parameter int AW = 64,
  parameter int SZW = 6,
  parameter int SH_SHORT = 3,
  parameter int SH_LONG = 5
) (
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  index,
  input  logic [SZW-1:0] size_log2,
  input  logic           is_long,
  output logic [AW-1:0]  ent_addr,
  output logic [AW-1:0]  tbl_mask
);
  logic [AW-1:0] shifted;

  always_comb begin
    tbl_mask = (AW'(1) << size_log2) - AW'(1);
    shifted  = is_long ? (index << SH_LONG) : (index << SH_SHORT);
    // low bits replaced, upper bits of the base kept: no carry upward
    ent_addr = (base & ~tbl_mask) | (shifted & tbl_mask);
  end
endmodule

// File: rtl/hptw_beat_buf.sv
module hptw_beat_buf #(
  parameter int BEATS = 4,
  parameter int W = 64,
  parameter int CW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_idx,
  input  logic              swap,
  input  logic [W-1:0]      wr_data,
  output logic [BEATS*W-1:0] rd_flat
);
  localparam int IW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int NBYTE = W / 8;

  logic [W-1:0] swapped;
  logic [W-1:0] mem [BEATS];

  for (genvar g = 0; g < NBYTE; g++) begin : g_swap
    assign swapped[g*8 +: 8] = wr_data[W-8-g*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx[IW-1:0]] <= swap ? swapped : wr_data;
  end

  for (genvar b = 0; b < BEATS; b++) begin : g_rd
    assign rd_flat[b*W +: W] = mem[b];
  end

  // R2: a write never targets a beat beyond the entry
  p_idx_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_idx) < BEATS))
    else $error("beat index out of range");
endmodule

// File: rtl/hptw_entry_chk.sv
module hptw_entry_chk #(
  parameter int W = 64,
  parameter logic [W-1:0] RSV0_MASK = 64'hFF00_0000_0000_0000,
  parameter logic [W-1:0] RSV1_MASK = 64'h0000_0000_0000_0003,
  parameter int ATTR_LSB = 2
) (
  input  logic [W-1:0] w0,
  input  logic [W-1:0] w1,
  input  logic         is_long,
  output logic         rsv
);
  logic [2:0] attr;
  logic       bad_enc;

  always_comb begin
    attr    = w0[ATTR_LSB +: 3];
    bad_enc = (attr == 3'd2) || (attr == 3'd3);
    rsv     = bad_enc || ((w0 & RSV0_MASK) != '0) ||
              (is_long && ((w1 & RSV1_MASK) != '0));
  end
endmodule

// File: rtl/hptw_walker.sv
module hptw_walker
  import hptw_pkg::*;
#(
  parameter int AW = 64,
  parameter int SZW = 6,
  parameter int BEAT_W = 64,
  parameter int SHORT_BYTES = 8,
  parameter int LONG_BYTES = 32,
  parameter logic [BEAT_W-1:0] RSV0_MASK = 64'hFF00_0000_0000_0000,
  parameter logic [BEAT_W-1:0] RSV1_MASK = 64'h0000_0000_0000_0003,
  parameter int ATTR_LSB = 2,
  localparam int ENT_W = (LONG_BYTES / (BEAT_W / 8)) * BEAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_vaddr,
  input  logic [AW-1:0]     req_index,
  input  logic [AW-1:0]     req_base,
  input  logic [SZW-1:0]    req_size_log2,
  input  logic              req_long,
  input  logic              req_is_data,
  input  logic              req_spec,
  input  logic              req_uncached,
  input  logic              req_xlat_fault,
  input  logic              req_xlat_miss,
  input  logic              cfg_big_endian,
  input  logic              cfg_ic,
  input  logic              commit,
  input  logic              cancel,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [AW-1:0]     mem_rd_addr,
  output logic [1:0]        mem_rd_priv,
  input  logic              mem_data_valid,
  input  logic [BEAT_W-1:0] mem_data,
  input  logic              snp_valid,
  input  logic [AW-1:0]     snp_addr,
  input  logic              pur_valid,
  output logic              pur_ready,
  input  logic [AW-1:0]     pur_lo,
  input  logic [AW-1:0]     pur_hi,
  output logic              ins_valid,
  output logic              ins_long,
  output logic [AW-1:0]     ins_vaddr,
  output logic [ENT_W-1:0]  ins_entry,
  output logic              flt_valid,
  output logic [2:0]        flt_code,
  output logic              done
);
  localparam int BEAT_BYTES = BEAT_W / 8;
  localparam int LONG_BEATS = LONG_BYTES / BEAT_BYTES;
  localparam int CNT_W = $clog2(LONG_BEATS + 1);
  localparam int BEAT_SH = $clog2(BEAT_BYTES);
  localparam int SH_SHORT = $clog2(SHORT_BYTES);
  localparam int SH_LONG = $clog2(LONG_BYTES);

  walk_st_t st;
  logic [AW-1:0] vaddr_q, ent_q, ent_c, mask_c;
  logic          long_q, data_q, spec_q, unc_q, be_q, tear_q;
  logic [2:0]    code_q;
  logic [CNT_W-1:0] beat_q, last_c;
  logic [ENT_W-1:0] flat;
  logic [BEAT_W-1:0] w0, w1;
  logic rsv_c, snp_hit, pur_overlap, wr_en;
  logic [2:0] miss_in, miss_q;

  hptw_addr #(.AW(AW), .SZW(SZW), .SH_SHORT(SH_SHORT), .SH_LONG(SH_LONG)) u_addr (
    .base(req_base), .index(req_index), .size_log2(req_size_log2),
    .is_long(req_long), .ent_addr(ent_c), .tbl_mask(mask_c)
  );

  assign wr_en = (st == ST_RD_WAIT) && mem_data_valid;

  hptw_beat_buf #(.BEATS(LONG_BEATS), .W(BEAT_W), .CW(CNT_W)) u_buf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(beat_q), .swap(be_q),
    .wr_data(mem_data), .rd_flat(flat)
  );

  assign w0 = flat[BEAT_W-1:0];
  assign w1 = flat[2*BEAT_W-1:BEAT_W];

  hptw_entry_chk #(.W(BEAT_W), .RSV0_MASK(RSV0_MASK), .RSV1_MASK(RSV1_MASK),
                   .ATTR_LSB(ATTR_LSB)) u_chk (
    .w0(w0), .w1(w1), .is_long(long_q), .rsv(rsv_c)
  );

  assign miss_in = req_is_data ? FC_DMISS : FC_IMISS;
  assign miss_q  = data_q ? FC_DMISS : FC_IMISS;
  assign last_c  = long_q ? CNT_W'(LONG_BEATS - 1) : '0;
  assign snp_hit = (snp_addr[AW-1:SH_LONG] == ent_q[AW-1:SH_LONG]);

  assign req_ready    = (st == ST_IDLE);
  assign mem_rd_valid = (st == ST_RD_REQ);
  assign mem_rd_addr  = ent_q + (AW'(beat_q) << BEAT_SH);
  assign mem_rd_priv  = WALK_PRIV;

  assign pur_overlap = (pur_lo <= vaddr_q) && (vaddr_q <= pur_hi);
  assign pur_ready   = (st == ST_IDLE) || !pur_overlap;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      vaddr_q   <= '0;
      ent_q     <= '0;
      long_q    <= 1'b0;
      data_q    <= 1'b0;
      spec_q    <= 1'b0;
      unc_q     <= 1'b0;
      be_q      <= 1'b0;
      tear_q    <= 1'b0;
      code_q    <= FC_NONE;
      beat_q    <= '0;
      ins_valid <= 1'b0;
      ins_long  <= 1'b0;
      ins_vaddr <= '0;
      ins_entry <= '0;
      flt_valid <= 1'b0;
      flt_code  <= FC_NONE;
      done      <= 1'b0;
    end else begin
      ins_valid <= 1'b0;
      flt_valid <= 1'b0;
      flt_code  <= FC_NONE;
      done      <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            vaddr_q <= req_vaddr;
            ent_q   <= ent_c;
            long_q  <= req_long;
            data_q  <= req_is_data;
            spec_q  <= req_spec;
            unc_q   <= req_uncached;
            be_q    <= cfg_big_endian;
            beat_q  <= '0;
            tear_q  <= 1'b0;
            if (req_uncached || req_xlat_fault) begin
              code_q <= miss_in;
              st     <= ST_FAULT;
            end else if (req_xlat_miss) begin
              code_q <= cfg_ic ? FC_XLAT : miss_in;
              st     <= ST_FAULT;
            end else begin
              st <= ST_RD_REQ;
            end
          end
        end
        ST_RD_REQ: if (mem_rd_ready) st <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (mem_data_valid) begin
            if (beat_q == last_c) st <= ST_CHECK;
            else begin
              beat_q <= beat_q + 1'b1;
              st     <= ST_RD_REQ;
            end
          end
        end
        ST_CHECK: begin
          if (tear_q || rsv_c) begin
            code_q <= miss_q;
            st     <= ST_FAULT;
          end else begin
            ins_valid <= 1'b1;
            ins_long  <= long_q;
            ins_vaddr <= vaddr_q;
            ins_entry <= long_q ? flat : {{(ENT_W-BEAT_W){1'b0}}, w0};
            done      <= 1'b1;
            st        <= ST_IDLE;
          end
        end
        ST_FAULT: begin
          if (spec_q) st <= ST_HOLD;
          else begin
            flt_valid <= 1'b1;
            flt_code  <= code_q;
            done      <= 1'b1;
            st        <= ST_IDLE;
          end
        end
        ST_HOLD: begin
          if (commit) begin
            flt_valid <= 1'b1;
            flt_code  <= code_q;
            done      <= 1'b1;
            st        <= ST_IDLE;
          end else if (cancel) begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
      // torn fetch: store into a long entry once part of it has been read
      if ((st == ST_RD_REQ || st == ST_RD_WAIT) && beat_q != '0 &&
          long_q && snp_valid && snp_hit)
        tear_q <= 1'b1;
    end
  end

  // R1: table base is aligned to the table size (input assumption)
  p_base_aligned_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |-> ((req_base & mask_c) == '0))
    else $error("misaligned table base");

  // R1: a read request stays put until accepted
  p_rd_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)))
    else $error("read request dropped or moved");

  // R5: an uncached walk issues no read
  p_no_read_uncached_r5: assert property (@(posedge clk) disable iff (rst)
    (unc_q && st != ST_IDLE) |-> !mem_rd_valid)
    else $error("read issued for uncached table");

  // R10: a purge is only held back while a walk is active
  p_purge_held_r10: assert property (@(posedge clk) disable iff (rst)
    (pur_valid && !pur_ready) |-> (st != ST_IDLE))
    else $error("purge stalled while idle");

  // R11: a held speculative fault stays silent until commit
  p_spec_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD && !commit) |=> !done)
    else $error("held fault leaked");

  // R12: exactly one result with each done
  p_one_result_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> $onehot({ins_valid, flt_valid}))
    else $error("done without a single result");

  // R12: a fault always carries a code
  p_code_set_r12: assert property (@(posedge clk) disable iff (rst)
    flt_valid |-> (flt_code != FC_NONE))
    else $error("fault without code");

  // R12: done never lasts two cycles
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done)
    else $error("done longer than a cycle");
endmodule

// File: tb/test_hptw_walker.sv
module test_hptw_walker;
  localparam int AW = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_long = 0, req_is_data = 0, req_spec = 0;
  logic req_uncached = 0, req_xlat_fault = 0, req_xlat_miss = 0;
  logic cfg_big_endian = 0, cfg_ic = 0, commit = 0, cancel = 0;
  logic [AW-1:0] req_vaddr = '0, req_index = '0, req_base = '0;
  logic [5:0] req_size_log2 = '0;
  logic req_ready, mem_rd_valid, mem_rd_ready = 1'b1, mem_data_valid = 1'b0;
  logic [AW-1:0] mem_rd_addr, snp_addr = '0, pur_lo = '0, pur_hi = '0, ins_vaddr;
  logic [1:0] mem_rd_priv;
  logic [63:0] mem_data = '0;
  logic snp_valid = 0, pur_valid = 0, pur_ready;
  logic ins_valid, ins_long, flt_valid, done;
  logic [255:0] ins_entry;
  logic [2:0] flt_code;

  hptw_walker i_hptw_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_index(req_index), .req_base(req_base),
    .req_size_log2(req_size_log2), .req_long(req_long), .req_is_data(req_is_data),
    .req_spec(req_spec), .req_uncached(req_uncached), .req_xlat_fault(req_xlat_fault),
    .req_xlat_miss(req_xlat_miss), .cfg_big_endian(cfg_big_endian), .cfg_ic(cfg_ic),
    .commit(commit), .cancel(cancel), .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr), .mem_rd_priv(mem_rd_priv),
    .mem_data_valid(mem_data_valid), .mem_data(mem_data), .snp_valid(snp_valid),
    .snp_addr(snp_addr), .pur_valid(pur_valid), .pur_ready(pur_ready),
    .pur_lo(pur_lo), .pur_hi(pur_hi), .ins_valid(ins_valid), .ins_long(ins_long),
    .ins_vaddr(ins_vaddr), .ins_entry(ins_entry), .flt_valid(flt_valid),
    .flt_code(flt_code), .done(done)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, n_done = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  typedef struct {
    bit            ins;
    logic [2:0]    code;
    logic [255:0]  ent;
    logic [AW-1:0] va;
    string         tag;
  } exp_t;
  exp_t sbq[$];

  // memory model state
  bit be_mem = 0;
  logic [63:0] poison = '0;
  int poison_beat = -1, beats_given = 0;
  int snoop_k = 0, snoop_d = 0, snoop_wait = -1;
  logic [AW-1:0] snoop_at = '0;
  logic [AW-1:0] rdq[$];
  bit pend = 0;
  logic [63:0] pend_data = '0;

  function automatic logic [63:0] cw(input logic [AW-1:0] a);
    return ({8'h00, a[55:0] ^ 56'h12_3456_789a_bcde}) & ~64'h1F;
  endfunction

  function automatic logic [63:0] bswap(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = v[56-i*8 +: 8];
    return r;
  endfunction

  function automatic logic [AW-1:0] ent_of(input logic [AW-1:0] b, input logic [AW-1:0] ix,
                                          input int szl, input bit lng);
    logic [AW-1:0] m;
    m = (AW'(1) << szl) - 1;
    return (b & ~m) | ((ix << (lng ? 5 : 3)) & m);
  endfunction

  function automatic logic [255:0] exp_ent(input logic [AW-1:0] a, input bit lng);
    logic [255:0] e;
    e = '0;
    for (int k = 0; k < (lng ? 4 : 1); k++)
      e[k*64 +: 64] = cw(a + AW'(8*k)) | ((k == poison_beat) ? poison : 64'h0);
    return e;
  endfunction

  // memory responder and snoop injector
  initial begin
    forever begin
      @(negedge clk);
      snp_valid = 0;
      if (snoop_wait == 0) begin
        snp_valid = 1; snp_addr = snoop_at; snoop_wait = -1;
      end else if (snoop_wait > 0) snoop_wait--;
      mem_data_valid = pend;
      mem_data = pend_data;
      if (pend) begin
        beats_given++;
        if (beats_given == snoop_k) begin
          if (snoop_d == 0) begin snp_valid = 1; snp_addr = snoop_at; end
          else snoop_wait = snoop_d - 1;
        end
      end
      pend = mem_rd_valid && mem_rd_ready;
      if (pend) begin
        logic [63:0] w;
        rdq.push_back(mem_rd_addr);
        chk(mem_rd_priv == 2'd0, "R4 read privilege", 256'(mem_rd_priv), 0);
        w = cw(mem_rd_addr) | ((beats_given == poison_beat) ? poison : 64'h0);
        pend_data = be_mem ? bswap(w) : w;
      end
    end
  end

  // scoreboard monitor
  initial begin
    bit prev = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (done) begin
          n_done++;
          if (prev) chk(0, "R12 done wider than one cycle", 1, 0);
          if (sbq.size() == 0) chk(0, "R12/R11 unexpected done", 1, 0);
          else begin
            exp_t e;
            e = sbq.pop_front();
            chk(ins_valid == e.ins && flt_valid == !e.ins, {e.tag, " result kind"},
                256'({ins_valid, flt_valid}), 256'({e.ins, !e.ins}));
            if (e.ins) begin
              chk(ins_entry == e.ent, {e.tag, " entry"}, ins_entry, e.ent);
              chk(ins_vaddr == e.va, {e.tag, " vaddr"}, 256'(ins_vaddr), 256'(e.va));
            end else
              chk(flt_code == e.code, {e.tag, " code"}, 256'(flt_code), 256'(e.code));
          end
        end
        prev = done;
      end
    end
  end

  task automatic push_ins(input logic [AW-1:0] va, input logic [255:0] ent, input string tag);
    exp_t e;
    e.ins = 1; e.code = 0; e.ent = ent; e.va = va; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic push_flt(input logic [2:0] code, input string tag);
    exp_t e;
    e.ins = 0; e.code = code; e.ent = '0; e.va = '0; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic walk(input logic [AW-1:0] va, input logic [AW-1:0] ix,
                      input logic [AW-1:0] b, input int szl, input bit lng,
                      input bit dat, input bit spec, input bit unc, input bit xf,
                      input bit xm, input bit be, input bit ic);
    while (!req_ready) @(negedge clk);
    rdq.delete();
    beats_given = 0;
    be_mem = be;
    req_vaddr = va; req_index = ix; req_base = b; req_size_log2 = 6'(szl);
    req_long = lng; req_is_data = dat; req_spec = spec; req_uncached = unc;
    req_xlat_fault = xf; req_xlat_miss = xm; cfg_big_endian = be; cfg_ic = ic;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while ((sbq.size() != 0 || !req_ready) && n < 300) begin
      @(negedge clk); n++;
    end
    chk(sbq.size() == 0, {tag, " drained"}, 256'(sbq.size()), 0);
  endtask

  task automatic chk_reads(input logic [AW-1:0] a, input int n, input string tag);
    chk(rdq.size() == n, {tag, " read count"}, 256'(rdq.size()), 256'(n));
    for (int k = 0; k < rdq.size() && k < n; k++)
      chk(rdq[k] == a + AW'(8*k), {tag, " beat address"}, 256'(rdq[k]), 256'(a + AW'(8*k)));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 0);
    finish_run();
  end

  initial begin
    logic [AW-1:0] b, a, va;
    int nd;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R13 reset state
    chk(req_ready == 1, "R13 req_ready", 256'(req_ready), 1);
    chk(pur_ready == 1, "R13 pur_ready", 256'(pur_ready), 1);
    chk({mem_rd_valid, done, ins_valid, flt_valid} == 4'b0, "R13 outputs idle",
        256'({mem_rd_valid, done, ins_valid, flt_valid}), 0);

    // R1 R2 short little-endian walk
    b = 64'h0000_4000_0000_0000; va = 64'h0000_0000_dead_b000;
    a = ent_of(b, 64'h3ff, 12, 0);
    chk(a == 64'h0000_4000_0000_0ff8, "R1 short entry address", 256'(a), 256'h4000_0000_0ff8);
    push_ins(va, exp_ent(a, 0), "R2 short insert");
    walk(va, 64'h3ff, b, 12, 0, 1, 0, 0, 0, 0, 0, 0);
    drain("R2 short");
    chk_reads(a, 1, "R1 short");

    // R1 R2 long walk, index overflow dropped
    b = 64'h0000_7000_0001_0000; va = 64'h0000_0000_1000_2000;
    a = ent_of(b, 64'h1234, 16, 1);
    chk(a == 64'h0000_7000_0001_4680, "R1 no carry", 256'(a), 256'h7000_0001_4680);
    push_ins(va, exp_ent(a, 1), "R2 long insert");
    walk(va, 64'h1234, b, 16, 1, 1, 0, 0, 0, 0, 0, 0);
    drain("R2 long");
    chk_reads(a, 4, "R1 long");

    // R3 big-endian, long and short
    push_ins(va, exp_ent(a, 1), "R3 long big-endian");
    walk(va, 64'h1234, b, 16, 1, 0, 0, 0, 0, 0, 1, 0);
    drain("R3 long");
    a = ent_of(b, 64'h7, 16, 0);
    push_ins(va, exp_ent(a, 0), "R3 short big-endian");
    walk(va, 64'h7, b, 16, 0, 0, 0, 0, 0, 0, 1, 0);
    drain("R3 short");

    // R5 uncached: no reads, code by access type
    push_flt(3'd1, "R5 uncached instr");
    walk(va, 64'h7, b, 16, 0, 0, 0, 1, 0, 0, 0, 0);
    drain("R5 instr");
    chk(rdq.size() == 0, "R5 no read instr", 256'(rdq.size()), 0);
    push_flt(3'd2, "R5 uncached data");
    walk(va, 64'h7, b, 16, 1, 1, 0, 1, 0, 0, 0, 1);
    drain("R5 data");
    chk(rdq.size() == 0, "R5 no read data", 256'(rdq.size()), 0);

    // R6 reserved bits and encodings
    poison = 64'h0100_0000_0000_0000; poison_beat = 0;
    push_flt(3'd2, "R6 short high bit");
    walk(va, 64'h7, b, 16, 0, 1, 0, 0, 0, 0, 0, 0);
    drain("R6 a");
    poison = 64'h08; poison_beat = 0;
    push_flt(3'd2, "R6 attr code 2");
    walk(va, 64'h7, b, 16, 1, 1, 0, 0, 0, 0, 1, 0);
    drain("R6 b");
    poison = 64'h01; poison_beat = 1;
    push_flt(3'd1, "R6 long word1 bit0");
    walk(va, 64'h7, b, 16, 1, 0, 0, 0, 0, 0, 0, 0);
    drain("R6 c");
    poison = 64'h01; poison_beat = 2;
    a = ent_of(b, 64'h7, 16, 1);
    push_ins(va, exp_ent(a, 1), "R6 word2 unchecked");
    walk(va, 64'h7, b, 16, 1, 0, 0, 0, 0, 0, 0, 0);
    drain("R6 d");
    poison = '0; poison_beat = -1;

    // R7 table translation fault
    push_flt(3'd2, "R7 xlat fault");
    walk(va, 64'h7, b, 16, 1, 1, 0, 0, 1, 0, 0, 1);
    drain("R7");
    chk(rdq.size() == 0, "R7 no read", 256'(rdq.size()), 0);

    // R8 table TLB miss
    push_flt(3'd3, "R8 ic=1");
    walk(va, 64'h7, b, 16, 0, 0, 0, 0, 0, 1, 0, 1);
    drain("R8 a");
    push_flt(3'd1, "R8 ic=0");
    walk(va, 64'h7, b, 16, 0, 0, 0, 0, 0, 1, 0, 0);
    drain("R8 b");

    // R9 snoops
    a = ent_of(b, 64'h20, 16, 1);
    snoop_at = a + 64'h10; snoop_k = 2; snoop_d = 0;
    push_flt(3'd2, "R9 torn long");
    walk(va, 64'h20, b, 16, 1, 1, 0, 0, 0, 0, 0, 0);
    drain("R9 a");
    snoop_k = 4; snoop_d = 1;
    push_ins(va, exp_ent(a, 1), "R9 store after read");
    walk(va, 64'h20, b, 16, 1, 1, 0, 0, 0, 0, 0, 0);
    drain("R9 b");
    a = ent_of(b, 64'h21, 16, 0);
    snoop_at = a; snoop_k = 1; snoop_d = 0;
    push_ins(va, exp_ent(a, 0), "R9 short store");
    walk(va, 64'h21, b, 16, 0, 1, 0, 0, 0, 0, 0, 0);
    drain("R9 c");
    snoop_k = 0;

    // R10 purge stall, R12 busy ready
    a = ent_of(b, 64'h40, 16, 1);
    push_ins(va, exp_ent(a, 1), "R10 walk");
    walk(va, 64'h40, b, 16, 1, 1, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    pur_valid = 1; pur_lo = va - 64'h100; pur_hi = va + 64'h100;
    #1;
    chk(pur_ready == 0, "R10 overlap held", 256'(pur_ready), 0);
    chk(req_ready == 0, "R12 busy not ready", 256'(req_ready), 0);
    pur_lo = va + 64'h1; pur_hi = va + 64'h1000;
    #1;
    chk(pur_ready == 1, "R10 disjoint ready", 256'(pur_ready), 1);
    pur_lo = va; pur_hi = va;
    drain("R10");
    #1;
    chk(pur_ready == 1, "R10 idle ready", 256'(pur_ready), 1);
    pur_valid = 0;

    // R11 speculative commit and cancel
    nd = n_done;
    walk(va, 64'h7, b, 16, 0, 1, 1, 1, 0, 0, 0, 0);
    repeat (10) @(negedge clk);
    chk(n_done == nd, "R11 held until commit", 256'(n_done), 256'(nd));
    push_flt(3'd2, "R11 committed fault");
    commit = 1; @(negedge clk); commit = 0;
    drain("R11 commit");
    nd = n_done;
    walk(va, 64'h7, b, 16, 0, 0, 1, 1, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    cancel = 1; @(negedge clk); cancel = 0;
    repeat (5) @(negedge clk);
    chk(n_done == nd, "R11 cancel silent", 256'(n_done), 256'(nd));
    chk(req_ready == 1, "R11 idle after cancel", 256'(req_ready), 1);
    a = ent_of(b, 64'h9, 16, 0);
    push_ins(va, exp_ent(a, 0), "R11 speculative insert");
    walk(va, 64'h9, b, 16, 0, 0, 1, 0, 0, 0, 0, 0);
    drain("R11 insert");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule